// File: doc/BRIEF.md
# Clear-on-read receive interrupt status register

This block collects single-cycle event pulses from eight receive-side sources into an 8-bit status register. Each status bit stays set from the moment its event arrives until the processor reads the register, and that read clears every bit at once. A mask register chooses which bits may raise the interrupt line. A global visibility control decides what happens to an event whose mask bit is set. With visibility on, the event is still recorded so it can be read back. With visibility off, the event is dropped.

The interrupt output is a level. It is the OR of all latched bits whose mask bit is clear. The same condition drives a per-register summary bit, which an upper-level interrupt collector can combine with others. Access goes through a simple synchronous port. A read strobe with an address returns the selected register one cycle later. A write strobe with an address updates the mask or the control register.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, the status register is 0x00, the mask register is 0xFF (all masked), visibility is off, and `irq_o` and `summary_o` are low.
- R2: An event pulse on a bit whose mask bit is clear sets that status bit, and the bit holds until a status read. Bit meaning, from bit 7 down: message end, frame start or frame invalid, sync format error, multiframe begin, then four further receive events in bits 3 to 0.
- R3: A read strobe at address 0 returns the status contents on `rdata_o` in the cycle after the strobe, and leaves every status bit cleared.
- R4: An event that arrives in the same cycle as a clearing status read is kept, and it is returned by the next status read.
- R5: With visibility off (control bit 0 = 0), an event whose mask bit is 1 is discarded and never latched.
- R6: With visibility on (control bit 0 = 1), an event whose mask bit is 1 is latched and can be read back.
- R7: Latched bits whose mask bit is 1 never raise `irq_o` or `summary_o`.
- R8: `irq_o` is high exactly while some latched bit has a clear mask bit. It stays high across idle cycles, falls only after a clearing read, and rises if a latched bit is later unmasked.
- R9: `summary_o` always equals `irq_o`.
- R10: The mask register (address 1) and the control register (address 2, bit 0 = visibility) can be written and read back. A write to address 0 has no effect on the status bits. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 8 | Single-cycle event pulses, one per status bit |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle after the strobe |
| irq_o | output | 1 | Level interrupt: some latched bit is unmasked |
| summary_o | output | 1 | Summary bit for an upper-level collector |

## Verification
The bench drives an event into the same cycle as a clearing read. A design where clear beats set would lose that event, and the second read would return zero. It latches masked events with visibility on and off. A design that ignores the visibility control would either drop readable events or store events that should be discarded. It also checks that such latched masked bits leave the interrupt low. A design that ORs raw status into the interrupt would raise it. Further cases cover unmasking an already latched bit, which must raise the line at once, and a write to the status address, which must not set or clear any bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_VIS_BIT = 0;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_stat_bits.sv
module irq_stat_bits #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] stat_q
);
  logic [NUM_EVT-1:0] stat_d;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_comb begin
      if (set_vec[i])  stat_d[i] = 1'b1;
      else if (clr_i)  stat_d[i] = 1'b0;
      else             stat_d[i] = stat_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end
  end

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((stat_q & ~$past(set_vec)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] mask_q,
  output logic               vis_q
);
  logic               mask_en;
  logic               ctrl_en;
  logic [NUM_EVT-1:0] mask_d;
  logic               vis_d;

  always_comb begin
    mask_en = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);
    ctrl_en = wr_en_i && (reg_sel_e'(addr_i) == SEL_CTRL);
    mask_d  = mask_en ? wdata_i : mask_q;
    vis_d   = ctrl_en ? wdata_i[CTRL_VIS_BIT] : vis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      vis_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      vis_q  <= vis_d;
    end
  end

  // R10
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT   = 8,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] rdata_o,
  output logic               irq_o,
  output logic               summary_o
);
  logic               rst_n_sync;
  logic [NUM_EVT-1:0] mask_q;
  logic               vis_q;
  logic [NUM_EVT-1:0] accept;
  logic [NUM_EVT-1:0] set_vec;
  logic               clr_stat;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] rdata_d;
  logic [NUM_EVT-1:0] rdata_q;
  logic [NUM_EVT-1:0] pend;

  irq_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_cfg_regs #(.NUM_EVT(NUM_EVT)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mask_q(mask_q), .vis_q(vis_q)
  );

  always_comb begin
    accept   = ~mask_q | {NUM_EVT{vis_q}};
    set_vec  = evt_i & accept;
    clr_stat = rd_en_i && (reg_sel_e'(addr_i) == SEL_STAT);
  end

  irq_stat_bits #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n_sync), .set_vec(set_vec),
    .clr_i(clr_stat), .stat_q(stat_q)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      unique case (reg_sel_e'(addr_i))
        SEL_STAT: rdata_d = stat_q;
        SEL_MASK: rdata_d = mask_q;
        SEL_CTRL: begin
          rdata_d = '0;
          rdata_d[CTRL_VIS_BIT] = vis_q;
        end
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign pend      = stat_q & ~mask_q;
  assign irq_o     = |pend;
  assign summary_o = |pend;
  assign rdata_o   = rdata_q;

  // R5
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !vis_q |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (clr_stat && evt_i == '0) |=> !irq_o);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_o && !clr_stat && !wr_en_i) |=> irq_o);

  // R9
  summary_eq_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    summary_o == irq_o);
endmodule

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i;
  logic       rd_en_i;
  logic       wr_en_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       summary_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_reg u_irq_status_reg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .summary_o(summary_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [7:0] ev, output logic [7:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a; evt_i = ev;
    @(negedge clk);
    rd_en_i = 1'b0; evt_i = '0;
    d = rdata_o;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    chk("R1 summary", {7'b0, summary_o}, 8'h00);
    reg_rd(2'd1, 8'h00, d); chk("R1 mask", d, 8'hFF);
    reg_rd(2'd2, 8'h00, d); chk("R1 ctrl", d, 8'h00);
    pulse(8'hFF);
    reg_rd(2'd0, 8'h00, d); chk("R1 status empty (all masked)", d, 8'h00);
  endtask

  task automatic t_latch_and_clear;
    logic [7:0] d;
    reg_wr(2'd1, 8'h00);
    pulse(8'h80);
    repeat (3) @(negedge clk);
    chk("R2 irq held", {7'b0, irq_o}, 8'h01);
    chk("R9 summary", {7'b0, summary_o}, 8'h01);
    pulse(8'h09);
    reg_rd(2'd0, 8'h00, d); chk("R2 status bits", d, 8'h89);
    chk("R3 irq cleared", {7'b0, irq_o}, 8'h00);
    reg_rd(2'd0, 8'h00, d); chk("R3 status cleared", d, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    pulse(8'h01);
    reg_rd(2'd0, 8'h10, d); chk("R4 first read", d, 8'h01);
    chk("R4 irq kept", {7'b0, irq_o}, 8'h01);
    reg_rd(2'd0, 8'h00, d); chk("R4 kept event", d, 8'h10);
  endtask

  task automatic t_discard;
    logic [7:0] d;
    reg_wr(2'd1, 8'hF0);
    reg_wr(2'd2, 8'h00);
    pulse(8'h32);
    reg_rd(2'd0, 8'h00, d); chk("R5 masked dropped", d, 8'h02);
  endtask

  task automatic t_visible;
    logic [7:0] d;
    reg_wr(2'd2, 8'h01);
    pulse(8'h40);
    repeat (2) @(negedge clk);
    chk("R7 irq low", {7'b0, irq_o}, 8'h00);
    chk("R7 summary low", {7'b0, summary_o}, 8'h00);
    pulse(8'h04);
    chk("R8 unmasked raises irq", {7'b0, irq_o}, 8'h01);
    reg_rd(2'd0, 8'h00, d); chk("R6 masked visible", d, 8'h44);
  endtask

  task automatic t_unmask_late;
    logic [7:0] d;
    pulse(8'h20);
    chk("R7 masked latched irq", {7'b0, irq_o}, 8'h00);
    reg_wr(2'd1, 8'h00);
    chk("R8 irq on unmask", {7'b0, irq_o}, 8'h01);
    chk("R9 summary on unmask", {7'b0, summary_o}, 8'h01);
    reg_rd(2'd0, 8'h00, d); chk("R8 read value", d, 8'h20);
    chk("R8 irq after read", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    reg_wr(2'd1, 8'h5A);
    reg_rd(2'd1, 8'h00, d); chk("R10 mask readback", d, 8'h5A);
    reg_wr(2'd2, 8'h00);
    reg_rd(2'd2, 8'h00, d); chk("R10 ctrl readback", d, 8'h00);
    reg_wr(2'd0, 8'hFF);
    chk("R10 status write irq", {7'b0, irq_o}, 8'h00);
    reg_rd(2'd0, 8'h00, d); chk("R10 status write ignored", d, 8'h00);
    reg_rd(2'd3, 8'h00, d); chk("R10 unused addr", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; rd_en_i = 1'b0; wr_en_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch_and_clear();
    t_collision();
    t_discard();
    t_visible();
    t_unmask_late();
    t_cfg();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule